// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the current window pointer of a windowed integer register file whose window count is set by a parameter. It accepts four kinds of request: a save, which moves one window down; a restore, which moves one window up; a return from a trap handler; and a software write of the processor status word. Before any pointer move commits, the target window is checked against a per-window invalid mask. A blocked move produces a trap request instead, and the pointer stays where it was.

The block also holds the status word's single-bit and multi-bit fields in separate registers. From those registers and the pointer it builds the full status word that software reads. The mask has its own write port. Trap requests leave the block as a one-hot cause vector that is high for exactly one cycle. The register storage, trap vectoring and interrupt arbitration sit in neighbouring blocks.

Top module: `wpc_ctrl`

## Requirements
- R1: After synchronous reset the pointer is 0, the mask is all zero, no trap cause is raised, and the status word reads 0x0000_0080 (supervisor bit set, every other field clear).
- R2: An accepted save whose target window is valid moves the pointer to pointer-1 on the same clock edge, and wraps from 0 to NWIN-1.
- R3: An accepted restore whose target window is valid moves the pointer to pointer+1, and wraps from NWIN-1 to 0.
- R4: When the mask bit indexed by the target pointer is 1, a save raises overflow (cause bit 0) and a restore raises underflow (cause bit 1). In both cases the pointer and the status fields stay unchanged.
- R5: A return-from-trap while the trap-enable bit is 1 raises illegal-instruction (cause bit 2) and changes no state.
- R6: A return-from-trap while trap-enable is 0 always sets trap-enable to 1. If the mask bit of pointer+1 (with wrap) is set, it raises underflow, and the pointer and supervisor bit stay unchanged.
- R7: A return-from-trap that passes both checks sets trap-enable, moves the pointer to pointer+1 with wrap, and copies the previous-supervisor bit into the supervisor bit.
- R8: A status-word write whose pointer field (bits 4:0) is NWIN or more raises illegal-instruction and changes no state.
- R9: A legal status-word write loads every field. The status word is laid out as: pointer in bits 4:0, trap-enable in bit 5, previous-supervisor in bit 6, supervisor in bit 7, interrupt level in bits 11:8, coprocessor-enable in bit 12, and the condition codes C, V, Z, N in bits 20, 21, 22, 23. All other bits read as zero.
- R10: Only one request is serviced per cycle. The priority order is status write, then return-from-trap, then save, then restore. Requests that lose the arbitration are dropped without effect.
- R11: A mask write takes effect on the next cycle. A move or return in the same cycle as the mask write is still checked against the old mask.
- R12: The trap cause is registered and is high for the cycle after the request. It is at most one-hot, and it is zero in any cycle whose request was accepted or absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| save_req | input | 1 | Move one window down |
| restore_req | input | 1 | Move one window up |
| rett_req | input | 1 | Return from trap handler |
| sw_wr_en | input | 1 | Write the status word |
| sw_wr_data | input | 32 | Status word value to write |
| mask_wr_en | input | 1 | Write the window-invalid mask |
| mask_wr_data | input | NWIN | New mask value, one bit per window |
| sw_rd_data | output | 32 | Assembled status word |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| trap_cause | output | 3 | One-hot trap request: bit 0 overflow, bit 1 underflow, bit 2 illegal |

## Verification
The hardest case to reach is a return-from-trap that underflows. Trap-enable must be clear, and the mask bit one above the pointer must be set. Reset leaves trap-enable clear, and the only other way to clear it is a status write. The directed part of the stimulus therefore writes the mask and issues the return straight after reset. It then checks that trap-enable became 1 while the pointer and supervisor bit stayed put. The random part clears trap-enable through status writes with in-range pointer fields often enough that both successful and failed returns occur many times. A behavioural model compares its results against the block on every cycle.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int SW_W     = 32;
    localparam int CWPF_W   = 5;
    localparam int ET_BIT   = 5;
    localparam int PS_BIT   = 6;
    localparam int S_BIT    = 7;
    localparam int PIL_LSB  = 8;
    localparam int PIL_W    = 4;
    localparam int EF_BIT   = 12;
    localparam int C_BIT    = 20;
    localparam int V_BIT    = 21;
    localparam int Z_BIT    = 22;
    localparam int N_BIT    = 23;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } icc_t;

    typedef struct packed {
        icc_t             icc;
        logic             ef;
        logic [PIL_W-1:0] pil;
        logic             s;
        logic             ps;
        logic             et;
    } flags_t;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'b000,
        CAUSE_WOVF = 3'b001,
        CAUSE_WUNF = 3'b010,
        CAUSE_ILL  = 3'b100
    } cause_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SWWR,
        OP_RETT,
        OP_SAVE,
        OP_RESTORE
    } op_e;

    typedef struct packed {
        cause_e cause;
        logic   cwp_we;
        logic   flags_ld;
        logic   et_set;
        logic   s_copy;
    } act_t;

    localparam flags_t FLAGS_RST = '{icc: '0, ef: 1'b0, pil: '0, s: 1'b1, ps: 1'b0, et: 1'b0};

    function automatic flags_t unpack_status(input logic [SW_W-1:0] w);
        flags_t f;
        f.icc.n = w[N_BIT];
        f.icc.z = w[Z_BIT];
        f.icc.v = w[V_BIT];
        f.icc.c = w[C_BIT];
        f.ef    = w[EF_BIT];
        f.pil   = w[PIL_LSB +: PIL_W];
        f.s     = w[S_BIT];
        f.ps    = w[PS_BIT];
        f.et    = w[ET_BIT];
        return f;
    endfunction

    function automatic logic [SW_W-1:0] pack_status(input flags_t f, input logic [CWPF_W-1:0] cwpf);
        logic [SW_W-1:0] w;
        w = '0;
        w[N_BIT]               = f.icc.n;
        w[Z_BIT]               = f.icc.z;
        w[V_BIT]               = f.icc.v;
        w[C_BIT]               = f.icc.c;
        w[EF_BIT]              = f.ef;
        w[PIL_LSB +: PIL_W]    = f.pil;
        w[S_BIT]               = f.s;
        w[PS_BIT]              = f.ps;
        w[ET_BIT]              = f.et;
        w[CWPF_W-1:0]          = cwpf;
        return w;
    endfunction

endpackage

// File: rtl/wpc_ring_step.sv
module wpc_ring_step #(
    parameter int NWIN = 8,
    localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [CW-1:0] cwp,
    output logic [CW-1:0] cwp_up,
    output logic [CW-1:0] cwp_dn
);

    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    generate
        if (NWIN == (1 << CW)) begin : g_pow2
            assign cwp_up = cwp + 1'b1;
            assign cwp_dn = cwp - 1'b1;
        end else begin : g_wrap
            assign cwp_up = (cwp == LAST) ? '0   : cwp + 1'b1;
            assign cwp_dn = (cwp == '0)   ? LAST : cwp - 1'b1;
        end
    endgenerate

endmodule

// File: rtl/wpc_arbiter.sv
module wpc_arbiter
    import wpc_pkg::*;
(
    input  logic sw_wr_en,
    input  logic rett_req,
    input  logic save_req,
    input  logic restore_req,
    output op_e  op
);

    localparam int NREQ = 4;
    localparam op_e PRIO_OP [NREQ] = '{OP_SWWR, OP_RETT, OP_SAVE, OP_RESTORE};

    logic [NREQ-1:0] req;
    assign req = {restore_req, save_req, rett_req, sw_wr_en};

    always_comb begin
        op = OP_IDLE;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) op = PRIO_OP[i];
        end
    end

endmodule

// File: rtl/wpc_guard.sv
module wpc_guard
    import wpc_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  op_e               op,
    input  logic [NWIN-1:0]   mask,
    input  logic [CW-1:0]     cwp_up,
    input  logic [CW-1:0]     cwp_dn,
    input  logic              et,
    input  logic [CWPF_W-1:0] sw_cwpf,
    output act_t              act,
    output logic [CW-1:0]     cwp_next
);

    logic sw_bad;
    assign sw_bad = ({1'b0, sw_cwpf} >= (CWPF_W + 1)'(NWIN));

    always_comb begin
        act      = '{cause: CAUSE_NONE, cwp_we: 1'b0, flags_ld: 1'b0, et_set: 1'b0, s_copy: 1'b0};
        cwp_next = cwp_up;
        unique case (op)
            OP_SWWR: begin
                if (sw_bad) begin
                    act.cause = CAUSE_ILL;
                end else begin
                    act.flags_ld = 1'b1;
                    act.cwp_we   = 1'b1;
                    cwp_next     = sw_cwpf[CW-1:0];
                end
            end
            OP_RETT: begin
                if (et) begin
                    act.cause = CAUSE_ILL;
                end else begin
                    act.et_set = 1'b1;
                    if (mask[cwp_up]) begin
                        act.cause = CAUSE_WUNF;
                    end else begin
                        act.cwp_we = 1'b1;
                        act.s_copy = 1'b1;
                    end
                end
            end
            OP_SAVE: begin
                cwp_next = cwp_dn;
                if (mask[cwp_dn]) act.cause  = CAUSE_WOVF;
                else              act.cwp_we = 1'b1;
            end
            OP_RESTORE: begin
                if (mask[cwp_up]) act.cause  = CAUSE_WUNF;
                else              act.cwp_we = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wpc_flags_reg.sv
module wpc_flags_reg
    import wpc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ld,
    input  flags_t ld_val,
    input  logic   et_set,
    input  logic   s_copy,
    output flags_t flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= FLAGS_RST;
        end else if (ld) begin
            flags <= ld_val;
        end else begin
            if (et_set) flags.et <= 1'b1;
            if (s_copy) flags.s  <= flags.ps;
        end
    end

endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            rett_req,
    input  logic            sw_wr_en,
    input  logic [31:0]     sw_wr_data,
    input  logic            mask_wr_en,
    input  logic [NWIN-1:0] mask_wr_data,
    output logic [31:0]     sw_rd_data,
    output logic [CW-1:0]   cwp_o,
    output logic [2:0]      trap_cause
);

    logic [CW-1:0]   cwp_q;
    logic [NWIN-1:0] mask_q;
    cause_e          cause_q;
    flags_t          flags;
    flags_t          sw_fields;
    op_e             op;
    act_t            act;
    logic [CW-1:0]   cwp_up;
    logic [CW-1:0]   cwp_dn;
    logic [CW-1:0]   cwp_next;
    logic            unused_rsvd;

    assign sw_fields   = unpack_status(sw_wr_data);
    assign unused_rsvd = ^{sw_wr_data[31:24], sw_wr_data[19:13]};

    wpc_arbiter u_arb (
        .sw_wr_en    (sw_wr_en),
        .rett_req    (rett_req),
        .save_req    (save_req),
        .restore_req (restore_req),
        .op          (op)
    );

    wpc_ring_step #(.NWIN(NWIN)) u_step (
        .cwp    (cwp_q),
        .cwp_up (cwp_up),
        .cwp_dn (cwp_dn)
    );

    wpc_guard #(.NWIN(NWIN)) u_guard (
        .op       (op),
        .mask     (mask_q),
        .cwp_up   (cwp_up),
        .cwp_dn   (cwp_dn),
        .et       (flags.et),
        .sw_cwpf  (sw_wr_data[CWPF_W-1:0]),
        .act      (act),
        .cwp_next (cwp_next)
    );

    wpc_flags_reg u_flags (
        .clk    (clk),
        .rst    (rst),
        .ld     (act.flags_ld),
        .ld_val (sw_fields),
        .et_set (act.et_set),
        .s_copy (act.s_copy),
        .flags  (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q   <= '0;
            mask_q  <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            cause_q <= act.cause;
            if (act.cwp_we) cwp_q  <= cwp_next;
            if (mask_wr_en) mask_q <= mask_wr_data;
        end
    end

    assign cwp_o      = cwp_q;
    assign trap_cause = cause_q;
    assign sw_rd_data = pack_status(flags, CWPF_W'(cwp_q));

endmodule

// File: rtl/wpc_chk.sv
module wpc_chk
    import wpc_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic            save_req,
    input logic            restore_req,
    input logic            rett_req,
    input logic            sw_wr_en,
    input logic [31:0]     sw_wr_data,
    input logic [31:0]     sw_rd_data,
    input logic [CW-1:0]   cwp_o,
    input logic [2:0]      trap_cause
);

    localparam logic [CW-1:0] LASTW = CW'(NWIN - 1);

    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trap_cause)); // R12

    AST_CWP_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(cwp_o) < NWIN); // R2

    AST_TRAP_HOLDS_CWP: assert property (@(posedge clk) disable iff (rst)
        (trap_cause != 3'b000) |-> (cwp_o == $past(cwp_o))); // R4

    AST_SAVE_STEP: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && save_req && !sw_wr_en && !rett_req) && trap_cause == 3'b000)
        |-> (cwp_o == (($past(cwp_o) == '0) ? LASTW : $past(cwp_o) - 1'b1))); // R2

    AST_RETT_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && rett_req && !sw_wr_en && sw_rd_data[ET_BIT])
        |-> (trap_cause == 3'b100 && $stable(sw_rd_data))); // R5

    AST_SW_BAD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && sw_wr_en && ({1'b0, sw_wr_data[4:0]} >= 6'(NWIN)))
        |-> (trap_cause == 3'b100 && $stable(sw_rd_data))); // R8

    AST_RETT_SETS_ET: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && rett_req && !sw_wr_en)
        |-> sw_rd_data[ET_BIT]); // R6

endmodule

bind wpc_ctrl wpc_chk #(.NWIN(NWIN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .save_req    (save_req),
    .restore_req (restore_req),
    .rett_req    (rett_req),
    .sw_wr_en    (sw_wr_en),
    .sw_wr_data  (sw_wr_data),
    .sw_rd_data  (sw_rd_data),
    .cwp_o       (cwp_o),
    .trap_cause  (trap_cause)
);

// File: tb/wpc_ctrl_tb_top.sv
module wpc_ctrl_tb_top;

    localparam int NWIN = 8;
    localparam int CW   = $clog2(NWIN);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            save_req = 1'b0;
    logic            restore_req = 1'b0;
    logic            rett_req = 1'b0;
    logic            sw_wr_en = 1'b0;
    logic [31:0]     sw_wr_data = '0;
    logic            mask_wr_en = 1'b0;
    logic [NWIN-1:0] mask_wr_data = '0;
    logic [31:0]     sw_rd_data;
    logic [CW-1:0]   cwp_o;
    logic [2:0]      trap_cause;

    always #4 clk = ~clk;

    wpc_ctrl #(.NWIN(NWIN)) dut_i (
        .clk, .rst, .save_req, .restore_req, .rett_req,
        .sw_wr_en, .sw_wr_data, .mask_wr_en, .mask_wr_data,
        .sw_rd_data, .cwp_o, .trap_cause
    );

    // behavioural reference state
    int              m_cwp, m_et, m_s, m_ps, m_ef, m_pil, m_n, m_z, m_v, m_c, m_cause;
    logic [NWIN-1:0] m_mask;
    string           m_tag;
    int              up, dn, nreq;
    int              n_cmp = 0;
    int              n_err = 0;
    bit              done = 0;

    function automatic int exp_word();
        return (m_n << 23) | (m_z << 22) | (m_v << 21) | (m_c << 20) | (m_ef << 12)
             | (m_pil << 8) | (m_s << 7) | (m_ps << 6) | (m_et << 5) | m_cwp;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cwp = 0; m_et = 0; m_s = 1; m_ps = 0; m_ef = 0; m_pil = 0;
            m_n = 0; m_z = 0; m_v = 0; m_c = 0; m_cause = 0; m_mask = '0; m_tag = "R1";
        end else begin
            nreq = int'(save_req) + int'(restore_req) + int'(rett_req) + int'(sw_wr_en);
            up = (m_cwp + 1) % NWIN;
            dn = (m_cwp + NWIN - 1) % NWIN;
            m_cause = 0;
            m_tag = "R11";
            if (sw_wr_en) begin
                if (int'(sw_wr_data[4:0]) >= NWIN) begin
                    m_cause = 4; m_tag = "R8";
                end else begin
                    m_cwp = int'(sw_wr_data[4:0]);
                    m_et = sw_wr_data[5]; m_ps = sw_wr_data[6]; m_s = sw_wr_data[7];
                    m_pil = int'(sw_wr_data[11:8]); m_ef = sw_wr_data[12];
                    m_c = sw_wr_data[20]; m_v = sw_wr_data[21];
                    m_z = sw_wr_data[22]; m_n = sw_wr_data[23];
                    m_tag = "R9";
                end
            end else if (rett_req) begin
                if (m_et == 1) begin
                    m_cause = 4; m_tag = "R5";
                end else begin
                    m_et = 1;
                    if (m_mask[up]) begin
                        m_cause = 2; m_tag = "R6";
                    end else begin
                        m_cwp = up; m_s = m_ps; m_tag = "R7";
                    end
                end
            end else if (save_req) begin
                if (m_mask[dn]) begin m_cause = 1; m_tag = "R4"; end
                else begin m_cwp = dn; m_tag = "R2"; end
            end else if (restore_req) begin
                if (m_mask[up]) begin m_cause = 2; m_tag = "R4"; end
                else begin m_cwp = up; m_tag = "R3"; end
            end
            if (nreq > 1) m_tag = "R10";
            if (mask_wr_en) m_mask = mask_wr_data;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            n_cmp++;
            if (int'(cwp_o) != m_cwp) begin
                n_err++;
                $display("FAIL %s pointer actual=%0d expected=%0d", m_tag, cwp_o, m_cwp);
            end
            n_cmp++;
            if (sw_rd_data != 32'(exp_word())) begin
                n_err++;
                $display("FAIL %s status actual=%h expected=%h", m_tag, sw_rd_data, 32'(exp_word()));
            end
            n_cmp++;
            if (int'(trap_cause) != m_cause) begin
                n_err++;
                $display("FAIL %s cause actual=%b expected=%b", m_tag, trap_cause, 3'(m_cause));
            end
            n_cmp++;
            if (!$onehot0(trap_cause)) begin
                n_err++;
                $display("FAIL R12 cause not one-hot actual=%b expected=at most one bit", trap_cause);
            end
        end
    end

    task automatic step(input bit sv, input bit rs, input bit rt, input bit sw,
                        input logic [31:0] swd, input bit mw, input logic [NWIN-1:0] md);
        @(negedge clk);
        save_req = sv; restore_req = rs; rett_req = rt;
        sw_wr_en = sw; sw_wr_data = swd;
        mask_wr_en = mw; mask_wr_data = md;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, '0, 0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;                               // R1: reset state compared next edge
        idle();
        step(1, 0, 0, 0, '0, 0, '0);              // R2: save 0 -> NWIN-1
        step(0, 1, 0, 0, '0, 0, '0);              // R3: restore NWIN-1 -> 0
        step(0, 0, 0, 0, '0, 1, 8'h80);           // R11: block window NWIN-1
        step(1, 0, 0, 0, '0, 0, '0);              // R4: overflow
        step(0, 0, 0, 0, '0, 1, 8'h02);           // R11
        step(0, 1, 0, 0, '0, 0, '0);              // R4: underflow
        step(0, 0, 1, 0, '0, 0, '0);              // R6: rett underflow, ET set
        step(0, 0, 1, 0, '0, 0, '0);              // R5: rett illegal
        step(0, 0, 0, 1, 32'h0000_0008, 0, '0);   // R8: pointer field = NWIN
        step(0, 0, 0, 1, 32'h00A0_1A43, 1, '0);   // R9: fields load, mask cleared
        step(0, 0, 1, 0, '0, 0, '0);              // R7: rett success, S <= PS
        step(1, 1, 0, 1, 32'h0000_0002, 0, '0);   // R10: status write wins
        step(1, 1, 0, 0, '0, 0, '0);              // R10: save beats restore
        step(1, 0, 0, 0, '0, 1, 8'h01);           // R11: save checks old mask
        step(0, 0, 0, 0, '0, 1, '0);
        step(0, 0, 1, 1, 32'h0000_0005, 0, '0);   // R10: status write beats rett
        idle();
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [31:0] d;
            r = int'($urandom % 16);
            d = $urandom;
            if ($urandom % 2 == 0) d[4:0] = 5'($urandom % NWIN);
            step(r < 4, (r >= 4 && r < 8) || ($urandom % 8 == 0), (r >= 8 && r < 11),
                 (r >= 11 && r < 13), d, ($urandom % 10 == 0), NWIN'($urandom & $urandom));
        end
        idle();
        idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

endmodule